// File: doc/BRIEF.md
# Input Trigger Wait Unit with Watchdog

This block performs one wait-for-trigger step of a step sequencer. The sequencer strobes `start_i` together with the level it wants (`want_high_i`), a two-bit detection mode and a three-bit watchdog code. The unit then watches a single trigger line until that line reaches the requested level, and answers with a one-cycle `done_o` strobe. `delay_req_o` travels with that strobe and tells the sequencer whether to run its post-step delay before moving on.

The trigger first passes through a two-flop synchronizer. Detection and the watchdog advance only on cycles where the prescaled tick `tick_i` is high. Mode bit 1 selects level detection (1) or edge detection (0). Mode bit 0 set means the step delay is skipped on exit. A nonzero watchdog code aborts a wait that runs too long. The abort ends the step with a done strobe, asserts no delay request, and raises a sticky timeout flag that stays up until `wdog_clr_i` clears it.

Top module: `trig_wait_unit`

## Requirements
- R1: In level mode (mode bit 1 = 1), the wait completes on the first evaluating tick at which the synchronized trigger equals the requested level. This includes the first tick after the start.
- R2: In edge mode (mode bit 1 = 0), the wait completes only when the synchronized trigger moves into the requested level between two consecutive samples. The first sample is taken in the start cycle. An input that is already at the level when the wait starts does not complete it.
- R3: When a wait completes, `delay_req_o` equals the inverse of mode bit 0: it is 1 for codes 00 and 10 and 0 for codes 01 and 11. It is never high without `done_o`.
- R4: A wait is evaluated only on tick cycles. `done_o` is a one-cycle pulse and appears in the cycle after the evaluating tick.
- R5: The trigger passes through two clock-domain flops. A change must be present for two clock edges before the tick edge that evaluates it.
- R6: Watchdog code n in 1..7 ends the wait on the 2^(n+2)-th tick after the start, giving 8 to 512 ticks. Code 0 never ends a wait.
- R7: The watchdog count restarts from zero at every accepted start.
- R8: A timeout raises `done_o` with `delay_req_o` low and sets `timeout_o`. `timeout_o` holds until `wdog_clr_i`. A set and a clear in the same cycle leave it set.
- R9: If completion and timeout fall on the same tick, completion wins: the delay request follows the mode and `timeout_o` is not set.
- R10: Mode, requested level and watchdog code are captured at the start. Changes to these inputs during a wait have no effect, and a start strobe during a wait is ignored.
- R11: After reset, `done_o`, `delay_req_o` and `timeout_o` are low and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled tick enable |
| start_i | input | 1 | Begin a wait (accepted while idle) |
| want_high_i | input | 1 | Requested level: 1 high, 0 low |
| trig_i | input | 1 | Asynchronous trigger input |
| mode_i | input | 2 | Bit 1: level (1) / edge (0); bit 0: skip delay |
| wdog_sel_i | input | 3 | Watchdog code, 0 disables |
| wdog_clr_i | input | 1 | Clears the timeout flag |
| done_o | output | 1 | Wait finished (one cycle) |
| delay_req_o | output | 1 | Run the step delay, valid with done_o |
| timeout_o | output | 1 | Sticky watchdog timeout flag |

## Verification
Each output is due at a fixed edge. A trigger change is usable at the third edge after it is driven. `done_o` and `delay_req_o` appear one edge after the tick that decides the wait. The timeout flag rises with that same done strobe and falls one edge after a clear. The bench drives all inputs at the falling edge and steps whole clock periods. It lets exactly two edges pass after each trigger change before it issues a one-cycle tick, and it samples the outputs at the falling edge right after that tick's rising edge. For watchdog runs it counts ticks one at a time and checks that no done appears before the last tick, then checks done and the timeout flag on the last one.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int unsigned MODE_W = 2;

    typedef logic [MODE_W-1:0] tw_mode_t;

    // bit 1 selects level detection, bit 0 suppresses the exit delay
    function automatic logic mode_is_level(input tw_mode_t m);
        return m[1];
    endfunction

    function automatic logic mode_skips_delay(input tw_mode_t m);
        return m[0];
    endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tw_detect.sv
module tw_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic eval_i,
    input  logic edge_i,
    input  logic want_i,
    input  logic trig_i,
    output logic hit_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (arm_i || eval_i) prev_d = trig_i;
        if (edge_i) hit_o = eval_i && (prev_q != want_i) && (trig_i == want_i);
        else        hit_o = eval_i && (trig_i == want_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned BASE  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1 + BASE;

    logic [CNT_W-1:0] cnt_d, cnt_q, last;

    always_comb begin
        last  = ~({CNT_W{1'b1}} << (32'(sel_i) + BASE));
        cnt_d = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (en_i) cnt_d = cnt_q + CNT_W'(1);
        expire_o = en_i && (sel_i != '0) && (cnt_q == last);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/trig_wait_unit.sv
module trig_wait_unit #(
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned WDOG_BASE   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     tick_i,
    input  logic                     start_i,
    input  logic                     want_high_i,
    input  logic                     trig_i,
    input  logic [tw_pkg::MODE_W-1:0] mode_i,
    input  logic [SEL_W-1:0]         wdog_sel_i,
    input  logic                     wdog_clr_i,
    output logic                     done_o,
    output logic                     delay_req_o,
    output logic                     timeout_o
);
    import tw_pkg::*;

    localparam int unsigned CFG_W = 1 + MODE_W + SEL_W;

    typedef struct packed {
        logic             waiting;
        logic             want;
        tw_mode_t         mode;
        logic [SEL_W-1:0] wsel;
        logic             done;
        logic             delay;
        logic             tmo;
    } st_t;

    st_t  st_d, st_q;
    logic trig_s, arm, eval, hit, expire;
    logic busy_w;
    logic [CFG_W-1:0] cfg_w;

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (trig_i),
        .q_o   (trig_s)
    );

    assign arm  = !st_q.waiting && start_i;
    assign eval = st_q.waiting && tick_i;

    tw_detect u_det (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .arm_i (arm),
        .eval_i(eval),
        .edge_i(!mode_is_level(st_q.mode)),
        .want_i(st_q.want),
        .trig_i(trig_s),
        .hit_o (hit)
    );

    tw_wdog #(.SEL_W(SEL_W), .BASE(WDOG_BASE)) u_wdog (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (arm),
        .en_i    (eval),
        .sel_i   (st_q.wsel),
        .expire_o(expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.delay = 1'b0;
        if (wdog_clr_i) st_d.tmo = 1'b0;
        if (arm) begin
            st_d.waiting = 1'b1;
            st_d.want    = want_high_i;
            st_d.mode    = mode_i;
            st_d.wsel    = wdog_sel_i;
        end else if (eval) begin
            if (hit) begin
                st_d.waiting = 1'b0;
                st_d.done    = 1'b1;
                st_d.delay   = !mode_skips_delay(st_q.mode);
            end else if (expire) begin
                st_d.waiting = 1'b0;
                st_d.done    = 1'b1;
                st_d.tmo     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o      = st_q.done;
    assign delay_req_o = st_q.delay;
    assign timeout_o   = st_q.tmo;
    assign busy_w      = st_q.waiting;
    assign cfg_w       = {st_q.want, st_q.mode, st_q.wsel};
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int unsigned CFG_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             start_i,
    input logic             wdog_clr_i,
    input logic             done_o,
    input logic             delay_req_o,
    input logic             timeout_o,
    input logic             busy_i,
    input logic [CFG_W-1:0] cfg_i
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R4
    AST_DONE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(tick_i) && $past(busy_i))); // R4
    AST_DELAY_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        delay_req_o |-> done_o); // R3
    AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o && !wdog_clr_i) |=> timeout_o); // R8
    AST_TMO_RISE_ENDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> (done_o && !delay_req_o)); // R8
    AST_START_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i) |=> busy_i); // R10
    AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> $stable(cfg_i)); // R10
endmodule

bind trig_wait_unit tw_checker #(.CFG_W(CFG_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .start_i    (start_i),
    .wdog_clr_i (wdog_clr_i),
    .done_o     (done_o),
    .delay_req_o(delay_req_o),
    .timeout_o  (timeout_o),
    .busy_i     (busy_w),
    .cfg_i      (cfg_w)
);

// File: tb/trig_wait_unit_test.sv
`timescale 1ns/1ps
module trig_wait_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, start = 1'b0, want = 1'b0, trig = 1'b0, clr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [2:0] wsel = 3'd0;
    logic       done, dreq, tmo;
    int         total = 0, bad = 0;

    always #2 clk = ~clk;

    trig_wait_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
        .want_high_i(want), .trig_i(trig), .mode_i(mode), .wdog_sel_i(wsel),
        .wdog_clr_i(clr), .done_o(done), .delay_req_o(dreq), .timeout_o(tmo)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_trig(input logic v);
        trig = v;
        step();
        step();
    endtask

    task automatic tick_once();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic begin_wait(input logic w, input logic [1:0] m, input logic [2:0] s);
        want = w; mode = m; wsel = s; start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic clear_tmo();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic test_reset();
        check("R11 done after reset", done, 0);
        check("R11 delay after reset", dreq, 0);
        check("R11 timeout after reset", tmo, 0);
    endtask

    task automatic test_level();
        set_trig(1'b1);
        begin_wait(1'b1, 2'b10, 3'd0);
        tick_once();
        check("R1 level done first tick", done, 1);
        check("R3 mode 10 delay", dreq, 1);
        step();
        check("R4 done one cycle", done, 0);
        set_trig(1'b0);
        begin_wait(1'b0, 2'b11, 3'd0);
        tick_once();
        check("R1 level low done", done, 1);
        check("R3 mode 11 no delay", dreq, 0);
        step();
    endtask

    task automatic test_no_tick();
        set_trig(1'b1);
        begin_wait(1'b1, 2'b10, 3'd0);
        for (int i = 0; i < 5; i++) step();
        check("R4 no evaluation without tick", done, 0);
        tick_once();
        check("R4 done after tick", done, 1);
        step();
    endtask

    task automatic test_edge();
        set_trig(1'b1);
        begin_wait(1'b1, 2'b00, 3'd0);
        tick_once();
        check("R2 edge ignores initial level", done, 0);
        set_trig(1'b0);
        tick_once();
        check("R2 edge no hit on wrong level", done, 0);
        set_trig(1'b1);
        tick_once();
        check("R2 edge rising completes", done, 1);
        check("R3 mode 00 delay", dreq, 1);
        step();
        begin_wait(1'b0, 2'b01, 3'd0);
        set_trig(1'b0);
        tick_once();
        check("R2 edge falling completes", done, 1);
        check("R3 mode 01 no delay", dreq, 0);
        step();
    endtask

    task automatic test_sync();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, 3'd0);
        trig = 1'b1;
        step();
        tick_once();
        check("R5 one edge is too early", done, 0);
        tick_once();
        check("R5 visible after two edges", done, 1);
        step();
    endtask

    task automatic run_wd(input logic [2:0] s);
        int lim = 1 << (s + 2);
        int early = 0;
        clear_tmo();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, s);
        for (int i = 0; i < lim - 1; i++) begin
            tick_once();
            if (done) early++;
        end
        check("R6 no done before limit", early, 0);
        tick_once();
        check("R6 done at limit", done, 1);
        check("R8 no delay on timeout", dreq, 0);
        check("R8 timeout set", tmo, 1);
        step();
    endtask

    task automatic test_wd_sticky();
        run_wd(3'd1);
        for (int i = 0; i < 4; i++) step();
        check("R8 timeout sticky", tmo, 1);
        clear_tmo();
        check("R8 timeout cleared", tmo, 0);
        run_wd(3'd3);
        run_wd(3'd7);
        clear_tmo();
    endtask

    task automatic test_wd_off();
        int early = 0;
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, 3'd0);
        for (int i = 0; i < 600; i++) begin
            tick_once();
            if (done) early++;
        end
        check("R6 code 0 never times out", early, 0);
        check("R6 code 0 timeout flag", tmo, 0);
        set_trig(1'b1);
        tick_once();
        check("R6 code 0 wait still completes", done, 1);
        step();
    endtask

    task automatic test_restart();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, 3'd1);
        for (int i = 0; i < 5; i++) tick_once();
        set_trig(1'b1);
        tick_once();
        check("R7 first wait completes", done, 1);
        step();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, 3'd1);
        for (int i = 0; i < 7; i++) tick_once();
        check("R7 count restarted", done, 0);
        clr = 1'b1;
        tick_once();
        clr = 1'b0;
        check("R7 timeout on eighth tick", done, 1);
        check("R8 set wins over clear", tmo, 1);
        clear_tmo();
        check("R8 clear after collision", tmo, 0);
    endtask

    task automatic test_tie();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, 3'd1);
        for (int i = 0; i < 7; i++) tick_once();
        set_trig(1'b1);
        tick_once();
        check("R9 completion wins done", done, 1);
        check("R9 completion wins delay", dreq, 1);
        check("R9 completion wins no timeout", tmo, 0);
        step();
    endtask

    task automatic test_latched();
        set_trig(1'b1);
        begin_wait(1'b1, 2'b10, 3'd0);
        mode = 2'b01;
        step();
        tick_once();
        check("R10 mode held at start", done, 1);
        check("R10 delay from held mode", dreq, 1);
        step();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b10, 3'd1);
        wsel = 3'd0;
        for (int i = 0; i < 8; i++) tick_once();
        check("R10 watchdog code held", tmo, 1);
        clear_tmo();
        set_trig(1'b0);
        begin_wait(1'b1, 2'b11, 3'd0);
        begin_wait(1'b0, 2'b11, 3'd0);
        tick_once();
        check("R10 start during wait ignored", done, 0);
        set_trig(1'b1);
        tick_once();
        check("R10 original wait completes", done, 1);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        step();
        test_level();
        test_no_tick();
        test_edge();
        test_sync();
        test_wd_sticky();
        test_wd_off();
        test_restart();
        test_tie();
        test_latched();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule